// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital control for a 10-bit successive-approximation converter. It divides the CPU clock down to a conversion clock and runs each conversion as a fixed sequence of 13 conversion-clock cycles. In that sequence it latches the input selection, fires a sample-and-hold strobe and steps a trial code, one bit at a time, against a comparator bit from the analog side. It then stores the result and raises a sticky completion flag. The analog parts are outside the block: it drives the trial code to the DAC and the hold strobe to the sample capacitor, and it reads back a single comparator bit.

A conversion can start in three ways. A software write sets the start bit, and the conversion then begins at the next conversion-clock boundary. A synchronised rising edge on the trigger pin starts a conversion at once and restarts the divider, so the time from that edge to the hold strobe does not depend on the divider's phase. In free-running mode each conversion is followed with no gap by the next one, and the start bit stays set. The conversion clock is never a real clock: the block produces a one-CPU-cycle enable pulse and keeps everything in the CPU clock domain.

Top module: `adc_seq_ctrl`

## Requirements
- R1: `adc_tick` pulses for one cycle every D CPU cycles. D is 2 to the power `pre_sel` (values 1 to 7), and `pre_sel` = 0 also gives D = 2.
- R2: In auto mode with `free_run` low, a rising edge on `trig_in` seen while idle passes a three-stage synchroniser, begins a conversion and restarts the divider. `sh_strobe` is then high in the cycle that follows the (2·D+1)th rising clock edge after the first edge that samples `trig_in` high.
- R3: `chan_q`, `ref_q` and the differential setting are latched when a conversion begins and hold until the next conversion begins. `sh_strobe` is high only together with `adc_tick`, on the tick that ends conversion cycle 2.
- R4: A conversion lasts 13 conversion-clock cycles. `busy` rises on the edge where it begins, and `done_flag` rises 13·D cycles later, at the same edge as the result update.
- R5: Over the 10 ticks after the hold strobe, `dac_code` searches from bit 9 down to bit 0. On each tick the trial bit is kept if `cmp_in` is 1 and cleared if it is 0. The final code is stored as the result.
- R6: When `auto_en` and `free_run` are both high, each completion begins the next conversion on the same edge. The hold strobes are then 13·D cycles apart and `start_bit` stays 1.
- R7: A one-cycle pulse on `start_wr` sets `start_bit`. A single conversion clears `start_bit` when it completes.
- R8: `done_flag` stays set until a cycle with `flag_clr` high clears it. A completion in the same cycle wins over the clear.
- R9: A trigger edge that arrives while `busy` is high is ignored: no new conversion follows when the current one ends.
- R10: `res_lo` holds result bits 7..0. `res_hi` bits 1..0 hold result bits 9..8. The upper six bits of `res_hi` are zero for a single-ended result and copies of result bit 9 (the sign) for a differential result.
- R11: While `adc_en` is low there are no ticks, and the block goes idle with `start_bit` cleared. `done_flag` and the result are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_en | input | 1 | Converter enable |
| pre_sel | input | 3 | Divider select, D = 2^pre_sel (0 treated as 1) |
| auto_en | input | 1 | Auto-start enable |
| free_run | input | 1 | Auto source is back-to-back restart instead of the trigger pin |
| trig_in | input | 1 | Asynchronous trigger source |
| start_wr | input | 1 | Pulse that sets the start bit |
| flag_clr | input | 1 | Pulse that clears the completion flag |
| chan_sel | input | 4 | Channel selection |
| ref_sel | input | 2 | Reference selection |
| diff_sel | input | 1 | Differential mode selection |
| cmp_in | input | 1 | Comparator: 1 when the input is at or above `dac_code` |
| adc_tick | output | 1 | Conversion-clock boundary enable |
| sh_strobe | output | 1 | Sample-and-hold strobe |
| dac_code | output | 10 | Trial code for the DAC |
| busy | output | 1 | A conversion is in progress |
| start_bit | output | 1 | Start bit |
| done_flag | output | 1 | Sticky completion flag |
| chan_q | output | 4 | Channel latched for the current conversion |
| ref_q | output | 2 | Reference latched for the current conversion |
| res_hi | output | 8 | Result high byte |
| res_lo | output | 8 | Result low byte |

## Verification
If the phase counter is wrong, `sh_strobe` or `done_flag` moves by a whole multiple of D cycles. The trigger latency and the completion time then fail on the first conversion. A divider that is not restarted on a trigger shows up as a latency that changes with the wait before the trigger. A wrong bit decision in the search shows up in the result bytes at the end of that same conversion. A start bit that is set or cleared wrongly shows up as an extra conversion or a missing one within 13·D cycles. The bench also models the port behaviour cycle by cycle, so any such fault is reported in the cycle where it first appears.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int RES_W    = 10;
  localparam int BYTE_W   = 8;
  localparam int EXT_W    = BYTE_W - (RES_W - BYTE_W);
  localparam int SEL_W    = 3;
  localparam int MAX_DIV  = 1 << ((1 << SEL_W) - 1);
  localparam int PRE_W    = $clog2(MAX_DIV);
  localparam int SH_CYC   = 2;
  localparam int CONV_CYC = SH_CYC + RES_W + 1;
  localparam int PH_W     = $clog2(CONV_CYC + 1);

  typedef logic [RES_W-1:0] code_t;

  // terminal count of the divider for a given select (D - 1)
  function automatic logic [PRE_W-1:0] lim_of(logic [SEL_W-1:0] sel);
    if (sel == '0) return PRE_W'(1);
    return PRE_W'((1 << sel) - 1);
  endfunction

  // one search decision: keep or drop the bit under test
  function automatic code_t sar_decide(code_t trial, code_t mask, logic keep);
    return keep ? trial : (trial & ~mask);
  endfunction

  function automatic logic [BYTE_W-1:0] hi_byte(code_t c, logic diff);
    return {{EXT_W{diff & c[RES_W-1]}}, c[RES_W-1:BYTE_W]};
  endfunction

  function automatic logic [BYTE_W-1:0] lo_byte(code_t c);
    return c[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler
  import adc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic             sync_clr,
  output logic             tick
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] lim;

  assign lim  = lim_of(sel);
  // >= keeps the period bounded when the select shrinks mid-count
  assign tick = en && (cnt_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (!en || sync_clr || tick) cnt_q <= '0;
    else                             cnt_q <= cnt_q + PRE_W'(1);
  end
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync #(
  parameter int STAGES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], din};
  end

  assign rise = sr_q[STAGES-2] & ~sr_q[STAGES-1];
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
  import adc_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  load,
  input  logic  step,
  input  logic  cmp,
  output code_t trial
);
  localparam code_t TOP_BIT = code_t'(1) << (RES_W - 1);

  code_t trial_q;
  code_t mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trial_q <= '0;
      mask_q  <= '0;
    end else if (clr) begin
      trial_q <= '0;
      mask_q  <= '0;
    end else if (load) begin
      trial_q <= TOP_BIT;
      mask_q  <= TOP_BIT;
    end else if (step) begin
      trial_q <= sar_decide(trial_q, mask_q, cmp) | (mask_q >> 1);
      mask_q  <= mask_q >> 1;
    end
  end

  assign trial = trial_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int CH_W        = 4,
  parameter int REF_W       = 2,
  parameter int SYNC_STAGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_en,
  input  logic [SEL_W-1:0]  pre_sel,
  input  logic              auto_en,
  input  logic              free_run,
  input  logic              trig_in,
  input  logic              start_wr,
  input  logic              flag_clr,
  input  logic [CH_W-1:0]   chan_sel,
  input  logic [REF_W-1:0]  ref_sel,
  input  logic              diff_sel,
  input  logic              cmp_in,
  output logic              adc_tick,
  output logic              sh_strobe,
  output logic [RES_W-1:0]  dac_code,
  output logic              busy,
  output logic              start_bit,
  output logic              done_flag,
  output logic [CH_W-1:0]   chan_q,
  output logic [REF_W-1:0]  ref_q,
  output logic [BYTE_W-1:0] res_hi,
  output logic [BYTE_W-1:0] res_lo
);
  localparam logic [PH_W-1:0] PH_IDLE  = '0;
  localparam logic [PH_W-1:0] PH_FIRST = PH_W'(1);
  localparam logic [PH_W-1:0] PH_SH    = PH_W'(SH_CYC);
  localparam logic [PH_W-1:0] PH_DONE  = PH_W'(CONV_CYC);

  logic [PH_W-1:0] phase_q;
  logic            start_q;
  logic            flag_q;
  logic            diff_q;
  logic            rdiff_q;
  code_t           res_q;
  code_t           trial;

  // named internal events
  logic tick;
  logic trig_rise;
  logic freerun_mode;
  logic idle;
  logic trig_take;
  logic sw_begin;
  logic conv_begin;
  logic conv_done;
  logic sh_evt;
  logic sar_step;
  logic pre_clear;

  adc_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .en(adc_en), .sel(pre_sel),
    .sync_clr(pre_clear), .tick(tick)
  );

  adc_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(trig_in), .rise(trig_rise)
  );

  adc_sar_core u_sar (
    .clk(clk), .rst_n(rst_n), .clr(!adc_en), .load(sh_evt),
    .step(sar_step), .cmp(cmp_in), .trial(trial)
  );

  assign freerun_mode = auto_en && free_run;
  assign idle         = (phase_q == PH_IDLE);
  assign trig_take    = adc_en && auto_en && !free_run && trig_rise && idle;
  assign pre_clear    = trig_take;
  assign sw_begin     = tick && start_q && idle && !trig_take;
  assign conv_done    = tick && (phase_q == PH_DONE);
  assign conv_begin   = trig_take || sw_begin || (conv_done && freerun_mode);
  assign sh_evt       = tick && (phase_q == PH_SH);
  assign sar_step     = tick && (phase_q > PH_SH) && (phase_q < PH_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    phase_q <= PH_IDLE;
    else if (!adc_en)              phase_q <= PH_IDLE;
    else if (conv_begin)           phase_q <= PH_FIRST;
    else if (conv_done)            phase_q <= PH_IDLE;
    else if (tick && !idle)        phase_q <= phase_q + PH_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              start_q <= 1'b0;
    else if (!adc_en)                        start_q <= 1'b0;
    else if (start_wr || trig_take)          start_q <= 1'b1;
    else if (conv_done && !freerun_mode)     start_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      ref_q  <= '0;
      diff_q <= 1'b0;
    end else if (conv_begin) begin
      chan_q <= chan_sel;
      ref_q  <= ref_sel;
      diff_q <= diff_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q   <= '0;
      rdiff_q <= 1'b0;
    end else if (conv_done) begin
      res_q   <= trial;
      rdiff_q <= diff_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (conv_done) flag_q <= 1'b1;
    else if (flag_clr)  flag_q <= 1'b0;
  end

  assign adc_tick  = tick;
  assign sh_strobe = sh_evt;
  assign dac_code  = trial;
  assign busy      = !idle;
  assign start_bit = start_q;
  assign done_flag = flag_q;
  assign res_hi    = hi_byte(res_q, rdiff_q);
  assign res_lo    = lo_byte(res_q);
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int CH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            adc_en,
  input logic            adc_tick,
  input logic            sh_strobe,
  input logic            conv_begin,
  input logic            conv_done,
  input logic            trig_rise,
  input logic            pre_clear,
  input logic            busy,
  input logic            start_bit,
  input logic            done_flag,
  input logic            flag_clr,
  input logic            freerun_mode,
  input logic [CH_W-1:0] chan_q
);
  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    adc_tick |=> !adc_tick);

  assert_sh_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sh_strobe |-> (adc_tick && busy));

  assert_chan_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !conv_begin) |=> $stable(chan_q));

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> done_flag);

  assert_freerun_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_en && freerun_mode && start_bit) |=> start_bit);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !flag_clr) |=> done_flag);

  assert_trig_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_rise && busy) |-> !pre_clear);

  assert_disabled_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_en |=> (!busy && !start_bit));

  assert_no_tick_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_en |-> !adc_tick);
endmodule

bind adc_seq_ctrl adc_seq_checker #(.CH_W(CH_W)) i_adc_seq_checker (
  .clk(clk), .rst_n(rst_n), .adc_en(adc_en), .adc_tick(adc_tick),
  .sh_strobe(sh_strobe), .conv_begin(conv_begin), .conv_done(conv_done),
  .trig_rise(trig_rise), .pre_clear(pre_clear), .busy(busy),
  .start_bit(start_bit), .done_flag(done_flag), .flag_clr(flag_clr),
  .freerun_mode(freerun_mode), .chan_q(chan_q)
);

// File: tb/test_adc_seq_ctrl.sv
module test_adc_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic adc_en = 0, auto_en = 0, free_run = 0, trig_in = 0;
  logic start_wr = 0, flag_clr = 0, diff_sel = 0;
  logic [2:0] pre_sel = 3'd1;
  logic [3:0] chan_sel = 0;
  logic [1:0] ref_sel = 0;
  logic [9:0] ain = 0;
  logic cmp_in;
  logic adc_tick, sh_strobe, busy, start_bit, done_flag;
  logic [9:0] dac_code;
  logic [3:0] chan_q;
  logic [1:0] ref_q;
  logic [7:0] res_hi, res_lo;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // behavioural reference state
  int m_cnt, m_phase;
  bit m_start, m_flag, m_diff, m_rdiff;
  int m_chan, m_ref;
  logic [9:0] m_held, m_res;
  bit [2:0] m_hist;
  int m_div;
  bit m_tk, m_evt, m_take, m_swb, m_done, m_fr;

  always #(CLK_PERIOD/2) clk = ~clk;

  // ideal comparator against the held sample
  assign cmp_in = (m_held >= dac_code);

  adc_seq_ctrl i_adc_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .adc_en(adc_en), .pre_sel(pre_sel),
    .auto_en(auto_en), .free_run(free_run), .trig_in(trig_in),
    .start_wr(start_wr), .flag_clr(flag_clr), .chan_sel(chan_sel),
    .ref_sel(ref_sel), .diff_sel(diff_sel), .cmp_in(cmp_in),
    .adc_tick(adc_tick), .sh_strobe(sh_strobe), .dac_code(dac_code),
    .busy(busy), .start_bit(start_bit), .done_flag(done_flag),
    .chan_q(chan_q), .ref_q(ref_q), .res_hi(res_hi), .res_lo(res_lo)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int div_of(int s);
    return (s == 0) ? 2 : (1 << s);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_phase = 0; m_start = 0; m_flag = 0; m_diff = 0; m_rdiff = 0;
      m_chan = 0; m_ref = 0; m_held = 0; m_res = 0; m_hist = 0;
    end else begin
      m_div  = div_of(pre_sel);
      m_tk   = adc_en && (m_cnt >= m_div - 1);
      m_evt  = m_hist[1] && !m_hist[2];
      m_fr   = auto_en && free_run;
      m_take = adc_en && auto_en && !free_run && m_evt && (m_phase == 0);
      m_swb  = m_tk && m_start && (m_phase == 0) && !m_take;
      m_done = m_tk && (m_phase == 13);
      m_hist = {m_hist[1:0], trig_in};
      if (m_done) begin m_flag = 1; m_res = m_held; m_rdiff = m_diff; end
      else if (flag_clr) m_flag = 0;
      if (m_tk && m_phase == 2) m_held = ain;
      if (!adc_en) begin
        m_cnt = 0; m_phase = 0; m_start = 0;
      end else begin
        m_cnt = (m_take || m_tk) ? 0 : m_cnt + 1;
        if (start_wr || m_take) m_start = 1;
        else if (m_done && !m_fr) m_start = 0;
        if (m_take || m_swb || (m_done && m_fr)) begin
          m_phase = 1; m_chan = chan_sel; m_ref = ref_sel; m_diff = diff_sel;
        end else if (m_done) m_phase = 0;
        else if (m_tk && m_phase > 0) m_phase++;
      end
    end
  end

  // compare against the model mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit etk = adc_en && (m_cnt >= div_of(pre_sel) - 1);
      automatic int ehi = (m_rdiff && m_res[9]) ? (8'hFC | m_res[9:8]) : m_res[9:8];
      check("R1 model tick", adc_tick, etk);
      check("R3 model strobe", sh_strobe, etk && m_phase == 2);
      check("R4 model busy", busy, m_phase != 0);
      check("R7 model start", start_bit, m_start);
      check("R8 model flag", done_flag, m_flag);
      check("R3 model chan", chan_q, m_chan);
      check("R3 model ref", ref_q, m_ref);
      check("R10 model hi", res_hi, ehi);
      check("R10 model lo", res_lo, m_res[7:0]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_start();
    start_wr = 1; step(1); start_wr = 0;
  endtask

  task automatic pulse_clr();
    flag_clr = 1; step(1); flag_clr = 0;
  endtask

  task automatic wait_flag();
    for (int i = 0; i < 5000 && !done_flag; i++) step(1);
  endtask

  task automatic trig_latency(int exp, string tag);
    int n;
    n = 0;
    trig_in = 1;
    while (!sh_strobe && n < 2000) begin step(1); n++; end
    check(tag, n, exp);
    wait_flag();
    trig_in = 0;
    pulse_clr();
  endtask

  initial begin
    int n;
    step(3);
    rst_n = 1; #1;
    // reset state
    check("R11 reset busy", busy, 0);
    check("R7 reset start", start_bit, 0);
    check("R8 reset flag", done_flag, 0);
    check("R10 reset lo", res_lo, 0);

    // R1: tick spacing
    adc_en = 1; pre_sel = 3; step(2);
    n = 0;
    for (int i = 0; i < 64; i++) begin if (adc_tick) n++; step(1); end
    check("R1 div8 ticks in 64", n, 8);
    pre_sel = 0; step(4);
    n = 0;
    for (int i = 0; i < 20; i++) begin if (adc_tick) n++; step(1); end
    check("R1 sel0 ticks in 20", n, 10);

    // R4/R5/R7/R10: single conversion, div 2
    pre_sel = 1; ain = 10'h2A5; chan_sel = 4'd5; ref_sel = 2'd2;
    pulse_start();
    check("R7 start set", start_bit, 1);
    for (int i = 0; i < 100 && !busy; i++) step(1);
    chan_sel = 4'd9; ref_sel = 2'd1;
    n = 0;
    do begin step(1); n++; end while (!done_flag && n < 1000);
    check("R4 duration 13*2", n, 26);
    check("R3 chan kept", chan_q, 5);
    check("R3 ref kept", ref_q, 2);
    check("R5 result lo", res_lo, 8'hA5);
    check("R10 single hi", res_hi, 8'h02);
    check("R7 start cleared", start_bit, 0);
    step(5);
    check("R8 flag sticky", done_flag, 1);
    pulse_clr();
    check("R8 flag cleared", done_flag, 0);

    // R10: differential results, new selection latched
    diff_sel = 1; ain = 10'h3F0; pulse_start(); wait_flag();
    check("R3 new chan", chan_q, 9);
    check("R10 diff neg hi", res_hi, 8'hFF);
    check("R10 diff neg lo", res_lo, 8'hF0);
    pulse_clr();
    ain = 10'h155; pulse_start(); wait_flag();
    check("R10 diff pos hi", res_hi, 8'h01);
    check("R5 result 155 lo", res_lo, 8'h55);
    pulse_clr();
    diff_sel = 0;

    // R2: trigger latency independent of divider phase
    auto_en = 1; pre_sel = 2; ain = 10'h0F3;
    step(3);
    trig_latency(10, "R2 latency div4 a");
    check("R5 result trig", res_lo, 8'hF3);
    step(6);
    trig_latency(10, "R2 latency div4 b");
    pre_sel = 1; step(7);
    trig_latency(6, "R2 latency div2");

    // R9: trigger while busy ignored
    step(5);
    trig_in = 1;
    for (int i = 0; i < 100 && !busy; i++) step(1);
    trig_in = 0; step(6); trig_in = 1;
    check("R9 busy at second edge", busy, 1);
    wait_flag();
    step(40);
    check("R9 no extra conversion", busy, 0);
    trig_in = 0; pulse_clr();

    // R6: free-running restarts
    free_run = 1; pulse_start();
    for (int i = 0; i < 500 && !sh_strobe; i++) step(1);
    n = 0;
    do begin step(1); n++; end while (!sh_strobe && n < 1000);
    check("R6 strobe spacing", n, 26);
    for (int i = 0; i < 30; i++) step(1);
    check("R6 start held", start_bit, 1);
    check("R6 still busy", busy, 1);
    check("R8 flag from free run", done_flag, 1);

    // R11: disable mid-conversion
    adc_en = 0; step(1);
    check("R11 idle", busy, 0);
    check("R11 start cleared", start_bit, 0);
    n = 0;
    for (int i = 0; i < 20; i++) begin if (adc_tick) n++; step(1); end
    check("R11 no ticks", n, 0);
    check("R11 flag kept", done_flag, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule